// File: doc/BRIEF.md
# C-4 Asynchronous Payload Row Builder

This block builds the byte stream for one 261-column row of a higher-order virtual container that carries a bit-asynchronous 139.264 Mbit/s tributary. A single start pulse begins a row. The controls are captured at that moment: the justification decision, the fill mode, the path overhead enable and byte, and the two overhead-communication bits. The block then emits 261 bytes on consecutive cycles. The first byte is the path overhead column. The other 260 bytes form twenty 13-byte blocks, and each block opens with a typed special byte.

Tributary bits come from an upstream elastic buffer. That buffer always presents its next eight bits, most significant bit first. In every cycle the block raises one strobe lane for each bit it consumes, so the buffer can advance its read pointer and track its fill level. The elastic store, the stuff decision, the pointer and the transport overhead are all outside this block.

Top module: `c4_row_builder`

## Requirements
- R1: While reset is high and in the first cycle after it, `row_valid`, `row_first`, `row_last` and `busy` are 0 and `bit_take` is 8'h00.
- R2: A `row_start` seen while idle launches a row. Its bytes appear on `row_valid` for 261 consecutive cycles, starting two clock edges after the start edge. `row_first` marks column 0 and `row_last` marks column 260. A `row_start` seen while `busy` is ignored.
- R3: Column 0 carries `poh_byte` when `poh_enable` is 1 and the fill mode is mapped (2'b00) or supervisory-unequipped (2'b10). In every other case column 0 is 8'h00.
- R4: Column 1+13*b holds the special byte of block b (b = 0..19). The special bytes run in the order W,X,Y,Y,Y,Y,Y,Y,X,Y,X,Y,Y,Y,X,Y,Y,X,Y,Z. Every other payload column holds 8 tributary bits, and the first-consumed bit is placed in bit 7. W is also 8 tributary bits.
- R5: An X byte has the justification control bit in bit 7, zeros in bits 6..2, and `ovhd_bits[1:0]` in bits 1..0.
- R6: A Y byte is 8'h00.
- R7: A Z byte has 6 tributary bits in bits 7..2, the justification opportunity bit in bit 1, and 0 in bit 0.
- R8: With `row_justify`=1, all five control bits are 1, the opportunity bit is 0 and is not taken from the tributary, and 1934 bits are consumed in the row. With `row_justify`=0, all five control bits are 0, the opportunity bit carries the next tributary bit, and 1935 bits are consumed.
- R9: `bit_take` has one lane for each presented bit, and the lanes are filled from bit 7 downward. The only values it takes are 8'h00, 8'hFF, 8'hFE and 8'hFC, and it is 8'h00 whenever the block is idle.
- R10: In fill mode unequipped (2'b01, and also 2'b11), all 261 bytes are 8'h00 and no tributary bit is consumed.
- R11: In fill mode supervisory-unequipped (2'b10), column 0 follows R3, all 260 payload bytes are 8'h00, and no tributary bit is consumed.
- R12: All row controls are sampled only on the accepted start. Changing them during the row has no effect on its bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_start | input | 1 | Start one row (accepted only when idle) |
| row_justify | input | 1 | 1 = use the opportunity bit as stuff for this row |
| row_fill | input | 2 | 00 mapped, 01 unequipped, 10 supervisory-unequipped, 11 unequipped |
| poh_enable | input | 1 | Insert the path overhead byte in column 0 |
| poh_byte | input | 8 | Path overhead byte value |
| ovhd_bits | input | 2 | Value of the two overhead bits in each X byte |
| trib_bits | input | 8 | Next eight tributary bits, first bit in bit 7 |
| bit_take | output | 8 | Per-bit consume strobes for `trib_bits` |
| busy | output | 1 | A row is being built |
| row_data | output | 8 | Row byte |
| row_valid | output | 1 | `row_data` holds a row byte |
| row_first | output | 1 | The byte is column 0 |
| row_last | output | 1 | The byte is column 260 |

## Verification
The bench aims at the Z byte under both justification settings. A builder that swaps the meaning of the decision, or that takes the stuff bit anyway, drifts one bit against the tributary, and every later row fails the comparison. The X bit layout and the irregular special-byte order are checked byte by byte, so a misplaced block type shows up as real data where zeros should be. The unequipped modes are run with tributary data available, which exposes a builder that still pulls bits. A second start in the middle of a row, together with controls flipped in the middle of a row, catches a builder that restarts or re-reads its configuration.

// File: rtl/c4rb_pkg.sv
package c4rb_pkg;

    localparam int unsigned C4_BLOCKS    = 20;
    localparam int unsigned C4_BLK_BYTES = 13;
    localparam int unsigned BYTE_W       = 8;

    typedef enum logic [1:0] {
        SP_W = 2'd0,
        SP_X = 2'd1,
        SP_Y = 2'd2,
        SP_Z = 2'd3
    } spec_e;

    typedef enum logic [1:0] {
        FILL_MAPPED = 2'b00,
        FILL_UNEQ   = 2'b01,
        FILL_SUPV   = 2'b10,
        FILL_BLANK  = 2'b11
    } fill_e;

    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_POH  = 2'd1,
        SLOT_SPEC = 2'd2,
        SLOT_INFO = 2'd3
    } slot_e;

    typedef struct packed {
        logic              justify;
        fill_e             fill;
        logic              poh_on;
        logic [BYTE_W-1:0] poh;
        logic [1:0]        obits;
    } row_cfg_t;

    typedef struct packed {
        slot_e kind;
        spec_e spec;
    } slot_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              first;
        logic              last;
    } out_beat_t;

    // Special byte type of each 13-byte block within a row
    function automatic spec_e spec_of(input int unsigned blk);
        spec_e s;
        case (blk)
            0:                  s = SP_W;
            1, 8, 10, 14, 17:   s = SP_X;
            19:                 s = SP_Z;
            default:            s = SP_Y;
        endcase
        return s;
    endfunction

    function automatic logic payload_live(input fill_e f);
        return (f == FILL_MAPPED);
    endfunction

    function automatic logic poh_live(input fill_e f);
        return (f == FILL_MAPPED) || (f == FILL_SUPV);
    endfunction

    // Thermometer mask: top n lanes set
    function automatic logic [BYTE_W-1:0] lead_mask(input int unsigned n);
        logic [BYTE_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < BYTE_W; i++) begin
            if (i < n) m[BYTE_W-1-i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/c4rb_seq.sv
module c4rb_seq
    import c4rb_pkg::*;
#(
    parameter int unsigned BLOCKS    = C4_BLOCKS,
    parameter int unsigned BLK_BYTES = C4_BLK_BYTES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  row_cfg_t cfg_in,
    output logic     busy,
    output logic     accept,
    output logic     at_last,
    output slot_t    slot,
    output row_cfg_t cfg
);

    localparam int unsigned BLK_IW = (BLOCKS    > 1) ? $clog2(BLOCKS)    : 1;
    localparam int unsigned POS_IW = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;
    localparam logic [BLK_IW-1:0] BLK_MAX = BLK_IW'(BLOCKS - 1);
    localparam logic [POS_IW-1:0] POS_MAX = POS_IW'(BLK_BYTES - 1);

    logic              at_poh;
    logic [BLK_IW-1:0] blk;
    logic [POS_IW-1:0] pos;

    assign accept  = start && !busy;
    assign at_last = busy && !at_poh && (blk == BLK_MAX) && (pos == POS_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            at_poh <= 1'b0;
            blk    <= '0;
            pos    <= '0;
            cfg    <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            at_poh <= 1'b1;
            blk    <= '0;
            pos    <= '0;
            cfg    <= cfg_in;
        end else if (busy) begin
            if (at_poh) begin
                at_poh <= 1'b0;
            end else if (pos == POS_MAX) begin
                pos <= '0;
                if (blk == BLK_MAX) begin
                    busy <= 1'b0;
                    blk  <= '0;
                end else begin
                    blk <= blk + 1'b1;
                end
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    always_comb begin
        slot.spec = spec_of(32'(blk));
        if (!busy)            slot.kind = SLOT_NONE;
        else if (at_poh)      slot.kind = SLOT_POH;
        else if (pos == '0)   slot.kind = SLOT_SPEC;
        else                  slot.kind = SLOT_INFO;
    end

    // R2: a running row keeps going until its last column
    p_run_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !at_last) |=> busy);

    // R2: after the last column the sequencer is idle
    p_row_ends_r2: assert property (@(posedge clk) disable iff (rst)
        at_last |=> !busy);

    // R12: the captured controls do not move during a row
    p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && !at_last) |=> $stable(cfg));

endmodule

// File: rtl/c4rb_byte_mux.sv
module c4rb_byte_mux
    import c4rb_pkg::*;
(
    input  slot_t              slot,
    input  row_cfg_t           cfg,
    input  logic [BYTE_W-1:0]  trib_bits,
    output logic [BYTE_W-1:0]  byte_out,
    output logic [BYTE_W-1:0]  take
);

    localparam int unsigned Z_INFO = 6;

    logic live;
    assign live = payload_live(cfg.fill);

    always_comb begin
        byte_out = '0;
        take     = '0;
        unique case (slot.kind)
            SLOT_NONE: begin
                byte_out = '0;
            end
            SLOT_POH: begin
                if (poh_live(cfg.fill) && cfg.poh_on) byte_out = cfg.poh;
            end
            SLOT_INFO: begin
                if (live) begin
                    byte_out = trib_bits;
                    take     = lead_mask(BYTE_W);
                end
            end
            SLOT_SPEC: begin
                if (live) begin
                    unique case (slot.spec)
                        SP_W: begin
                            byte_out = trib_bits;
                            take     = lead_mask(BYTE_W);
                        end
                        SP_X: begin
                            byte_out = {cfg.justify, 5'b00000, cfg.obits};
                        end
                        SP_Y: begin
                            byte_out = '0;
                        end
                        SP_Z: begin
                            if (cfg.justify) begin
                                byte_out = {trib_bits[7:2], 2'b00};
                                take     = lead_mask(Z_INFO);
                            end else begin
                                byte_out = {trib_bits[7:1], 1'b0};
                                take     = lead_mask(Z_INFO + 1);
                            end
                        end
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/c4rb_out_stage.sv
module c4rb_out_stage
    import c4rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  out_beat_t         in_beat,
    output logic [BYTE_W-1:0] row_data,
    output logic              row_valid,
    output logic              row_first,
    output logic              row_last
);

    out_beat_t beat_q;
    logic      valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            beat_q  <= in_valid ? in_beat : '0;
        end
    end

    assign row_data  = beat_q.data;
    assign row_valid = valid_q;
    assign row_first = beat_q.first;
    assign row_last  = beat_q.last;

    // R2: the last column is followed by a gap of at least one cycle
    p_gap_after_last_r2: assert property (@(posedge clk) disable iff (rst)
        row_last |=> !row_valid);

    // R2: row markers only ride on valid bytes
    p_marks_need_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (row_first || row_last) |-> row_valid);

    // R2: bytes of a row arrive back to back
    p_bytes_contiguous_r2: assert property (@(posedge clk) disable iff (rst)
        (row_valid && !row_last) |=> row_valid);

endmodule

// File: rtl/c4_row_builder.sv
module c4_row_builder
    import c4rb_pkg::*;
#(
    parameter int unsigned BLOCKS    = C4_BLOCKS,
    parameter int unsigned BLK_BYTES = C4_BLK_BYTES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        row_start,
    input  logic        row_justify,
    input  logic [1:0]  row_fill,
    input  logic        poh_enable,
    input  logic [7:0]  poh_byte,
    input  logic [1:0]  ovhd_bits,
    input  logic [7:0]  trib_bits,
    output logic [7:0]  bit_take,
    output logic        busy,
    output logic [7:0]  row_data,
    output logic        row_valid,
    output logic        row_first,
    output logic        row_last
);

    // Tributary bits per row when the opportunity bit is used as stuff
    localparam int unsigned BITS_JUST = BLOCKS * (BLK_BYTES - 1) * BYTE_W + BYTE_W + 6;
    localparam int unsigned TOT_W     = $clog2(BITS_JUST + 2);

    row_cfg_t  cfg_in, cfg;
    slot_t     slot;
    logic      accept, at_last;
    logic [BYTE_W-1:0] mux_byte;
    out_beat_t beat;

    always_comb begin
        cfg_in.justify = row_justify;
        cfg_in.fill    = fill_e'(row_fill);
        cfg_in.poh_on  = poh_enable;
        cfg_in.poh     = poh_byte;
        cfg_in.obits   = ovhd_bits;
    end

    c4rb_seq #(
        .BLOCKS    (BLOCKS),
        .BLK_BYTES (BLK_BYTES)
    ) i_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (row_start),
        .cfg_in  (cfg_in),
        .busy    (busy),
        .accept  (accept),
        .at_last (at_last),
        .slot    (slot),
        .cfg     (cfg)
    );

    c4rb_byte_mux i_mux (
        .slot      (slot),
        .cfg       (cfg),
        .trib_bits (trib_bits),
        .byte_out  (mux_byte),
        .take      (bit_take)
    );

    always_comb begin
        beat.data  = mux_byte;
        beat.first = (slot.kind == SLOT_POH);
        beat.last  = at_last;
    end

    c4rb_out_stage i_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (busy),
        .in_beat   (beat),
        .row_data  (row_data),
        .row_valid (row_valid),
        .row_first (row_first),
        .row_last  (row_last)
    );

    // Consumption tally used by the per-row bit budget check
    logic [TOT_W-1:0] take_total;
    logic [TOT_W-1:0] take_now;
    logic [TOT_W-1:0] budget;

    assign take_now = TOT_W'($countones(bit_take));
    assign budget   = !payload_live(cfg.fill) ? '0 :
                      (cfg.justify ? TOT_W'(BITS_JUST) : TOT_W'(BITS_JUST + 1));

    always_ff @(posedge clk) begin
        if (rst)         take_total <= '0;
        else if (accept) take_total <= '0;
        else if (busy)   take_total <= take_total + take_now;
    end

    // R8: the bits consumed in a row match the justification decision
    p_row_budget_r8: assert property (@(posedge clk) disable iff (rst)
        at_last |-> (take_total + take_now == budget));

    // R9: consume strobes fill from the top lane only
    p_take_shape_r9: assert property (@(posedge clk) disable iff (rst)
        (bit_take == 8'h00) || (bit_take == 8'hFF) ||
        (bit_take == 8'hFE) || (bit_take == 8'hFC));

    // R9: nothing is consumed while idle
    p_idle_no_take_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bit_take == 8'h00));

    // R10/R11: unequipped fills never pull tributary bits
    p_uneq_no_take_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && (cfg.fill != FILL_MAPPED)) |-> (bit_take == 8'h00));

endmodule

// File: tb/test_c4_row_builder.sv
module test_c4_row_builder;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       row_start = 1'b0;
    logic       row_justify = 1'b0;
    logic [1:0] row_fill = 2'b00;
    logic       poh_enable = 1'b0;
    logic [7:0] poh_byte = 8'h00;
    logic [1:0] ovhd_bits = 2'b00;
    logic [7:0] trib_bits;
    logic [7:0] bit_take;
    logic       busy;
    logic [7:0] row_data;
    logic       row_valid, row_first, row_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    c4_row_builder i_c4_row_builder (
        .clk         (clk),
        .rst         (rst),
        .row_start   (row_start),
        .row_justify (row_justify),
        .row_fill    (row_fill),
        .poh_enable  (poh_enable),
        .poh_byte    (poh_byte),
        .ovhd_bits   (ovhd_bits),
        .trib_bits   (trib_bits),
        .bit_take    (bit_take),
        .busy        (busy),
        .row_data    (row_data),
        .row_valid   (row_valid),
        .row_first   (row_first),
        .row_last    (row_last)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // ---------------- tributary source model ----------------
    function automatic logic src_bit(input int idx);
        logic [31:0] h;
        h = 32'(idx) * 32'h9E37_79B1;
        return h[20] ^ h[7] ^ h[29];
    endfunction

    int src_ptr;
    always_comb begin
        for (int k = 0; k < 8; k++) trib_bits[7-k] = src_bit(src_ptr + k);
    end
    always @(posedge clk) begin
        if (rst) src_ptr <= 0;
        else     src_ptr <= src_ptr + $countones(bit_take);
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [7:0] d;
        logic       f;
        logic       l;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    end_ptr_q[$];
    string end_tag_q[$];
    int    exp_ptr = 0;
    int    rows_done = 0;
    int    rows_issued = 0;
    bit    shape_bad = 1'b0;

    function automatic logic [7:0] take_bits(input int n);
        logic [7:0] v;
        v = 8'h00;
        for (int k = 0; k < n; k++) begin
            v[7-k] = src_bit(exp_ptr);
            exp_ptr++;
        end
        return v;
    endfunction

    function automatic void push_byte(input logic [7:0] d, input logic f,
                                      input logic l, input string tag);
        exp_t e;
        e.d = d; e.f = f; e.l = l;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endfunction

    // Expected row from the requirements (R3..R11)
    function automatic void push_row(input logic just, input logic [1:0] fill,
                                     input logic pen, input logic [7:0] poh,
                                     input logic [1:0] ob);
        string pat;
        logic  live, pvis;
        logic [7:0] sb;
        string stag;
        pat  = "WXYYYYYYXYXYYYXYYXYZ";
        live = (fill == 2'b00);
        pvis = (fill == 2'b00) || (fill == 2'b10);
        push_byte((pvis && pen) ? poh : 8'h00, 1'b1, 1'b0, "R3");
        for (int b = 0; b < 20; b++) begin
            sb = 8'h00;
            stag = "R4";
            if (live) begin
                case (pat[b])
                    "W": begin sb = take_bits(8); stag = "R4"; end
                    "X": begin sb = {just, 5'b00000, ob}; stag = "R5"; end
                    "Y": begin sb = 8'h00; stag = "R6"; end
                    default: begin
                        sb = take_bits(6);
                        if (!just) sb[1] = src_bit(exp_ptr);
                        if (!just) exp_ptr++;
                        stag = "R7/R8";
                    end
                endcase
            end else begin
                stag = (fill == 2'b10) ? "R11" : "R10";
            end
            push_byte(sb, 1'b0, 1'b0, stag);
            for (int c = 1; c < 13; c++) begin
                push_byte(live ? take_bits(8) : 8'h00, 1'b0,
                          (b == 19) && (c == 12),
                          live ? "R4" : ((fill == 2'b10) ? "R11" : "R10"));
            end
        end
        end_ptr_q.push_back(exp_ptr);
        end_tag_q.push_back(live ? "R8" : ((fill == 2'b10) ? "R11" : "R10"));
    endfunction

    // Monitor: pops and compares at the falling edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (busy && !((bit_take == 8'h00) || (bit_take == 8'hFF) ||
                          (bit_take == 8'hFE) || (bit_take == 8'hFC)))
                shape_bad = 1'b1;
            if (!busy && bit_take != 8'h00) shape_bad = 1'b1;
            if (row_valid) begin
                if (exp_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R2: unexpected byte got %02h exp none", row_data);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    tests++;
                    if (row_data !== e.d) begin
                        fails++;
                        $display("FAIL %s: byte got %02h exp %02h (row %0d)",
                                 t, row_data, e.d, rows_done);
                    end
                    tests++;
                    if (row_first !== e.f || row_last !== e.l) begin
                        fails++;
                        $display("FAIL R2: markers got %b%b exp %b%b",
                                 row_first, row_last, e.f, e.l);
                    end
                    if (e.l) begin
                        int    ep;
                        string et;
                        ep = end_ptr_q.pop_front();
                        et = end_tag_q.pop_front();
                        tests++;
                        if (src_ptr != ep) begin
                            fails++;
                            $display("FAIL %s: bits consumed got %0d exp %0d",
                                     et, src_ptr, ep);
                        end
                        tests++;
                        if (shape_bad) begin
                            fails++;
                            $display("FAIL R9: bit_take shape got bad exp thermometer");
                        end
                        shape_bad = 1'b0;
                        rows_done++;
                    end
                end
            end
        end
    end

    // Driver
    task automatic run_row(input logic just, input logic [1:0] fill,
                           input logic pen, input logic [7:0] poh,
                           input logic [1:0] ob, input bit scramble,
                           input bit mid_start);
        int target;
        @(negedge clk);
        row_justify = just; row_fill = fill; poh_enable = pen;
        poh_byte = poh; ovhd_bits = ob;
        push_row(just, fill, pen, poh, ob);
        rows_issued++;
        target = rows_issued;
        row_start = 1'b1;
        @(negedge clk);
        row_start = 1'b0;
        if (scramble) begin
            // R12: controls change mid-row and must be ignored
            row_justify = ~just; row_fill = ~fill; poh_enable = ~pen;
            poh_byte = ~poh; ovhd_bits = ~ob;
        end
        if (mid_start) begin
            // R2: a start while busy must not restart the row
            repeat (100) @(negedge clk);
            row_start = 1'b1;
            @(negedge clk);
            row_start = 1'b0;
        end
        while (rows_done < target && !finished) @(posedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        tests++;
        if (row_valid !== 1'b0 || busy !== 1'b0 || bit_take !== 8'h00 ||
            row_first !== 1'b0 || row_last !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset got v%b b%b t%02h exp v0 b0 t00",
                     row_valid, busy, bit_take);
        end
        // R2 timing: first byte two edges after the start edge
        @(negedge clk);
        row_justify = 1'b0; row_fill = 2'b00; poh_enable = 1'b1;
        poh_byte = 8'hA5; ovhd_bits = 2'b10;
        push_row(1'b0, 2'b00, 1'b1, 8'hA5, 2'b10);
        rows_issued++;
        row_start = 1'b1;
        @(negedge clk);
        row_start = 1'b0;
        tests++;
        if (row_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2: valid one edge after start got 1 exp 0");
        end
        @(negedge clk);
        tests++;
        if (row_valid !== 1'b1 || row_first !== 1'b1) begin
            fails++;
            $display("FAIL R2: first byte two edges after start got %b exp 1", row_valid);
        end
        while (rows_done < 1) @(posedge clk);

        run_row(1'b1, 2'b00, 1'b0, 8'h5A, 2'b01, 1'b0, 1'b0); // R8 justify, R3 disabled POH
        run_row(1'b1, 2'b01, 1'b1, 8'h77, 2'b11, 1'b0, 1'b0); // R10 unequipped
        run_row(1'b0, 2'b10, 1'b1, 8'h3C, 2'b10, 1'b0, 1'b0); // R11 supervisory, POH kept
        run_row(1'b1, 2'b10, 1'b0, 8'hC3, 2'b01, 1'b0, 1'b0); // R11 with POH off
        run_row(1'b0, 2'b00, 1'b1, 8'h96, 2'b01, 1'b1, 1'b1); // R12 and R2 ignored start
        run_row(1'b0, 2'b11, 1'b1, 8'h11, 2'b11, 1'b0, 1'b0); // R10 code 11
        run_row(1'b1, 2'b00, 1'b1, 8'hE7, 2'b11, 1'b1, 1'b0); // R5 R7 R8 back to back
        run_row(1'b0, 2'b00, 1'b1, 8'h42, 2'b00, 1'b0, 1'b0);

        repeat (5) @(negedge clk);
        tests++;
        if (exp_q.size() != 0 || row_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2: leftover bytes got %0d exp 0", exp_q.size());
        end
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        report();
    end

endmodule